// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands over several clock cycles and returns the full 64-bit product. A caller presents both operands and pulses `startI` while the unit is idle. The unit then runs one conditional-add-and-shift step per clock and signals completion with a single-cycle `doneO` pulse. The product stays on `productO` until the next accepted start.

The datapath has three parts:
- A multiplicand register that holds its value for the whole operation.
- A single 32-bit adder that works on the upper half of a 64-bit product register.
- The multiplier operand, which occupies the lower half of that same register.

On each step the register shifts right by one place. The adder's carry-out enters at the top bit, and the consumed multiplier bit leaves at the bottom. Because the multiplier lives in the product register, no separate multiplier register exists.

A control unit sequences the work. It drives the datapath through a small struct of strobes (load, step) and owns the iteration counter and the busy and done flags.

Top module: `shift_add_mult`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `busyO` and `doneO` are 0 and `productO` is 0.
- R2: When `startI` is 1 at a clock edge while `busyO` is 0, `busyO` is 1 from the next cycle on. In that same next cycle `productO[63:32]` is 0 and `productO[31:0]` equals the multiplier operand presented at that edge.
- R3: After an accepted start, `busyO` stays at 1 for exactly 32 consecutive cycles.
- R4: `doneO` is 1 for exactly one cycle. That cycle is the first cycle in which `busyO` is 0 again after a run.
- R5: In the cycle `doneO` is 1, `productO` equals the exact unsigned 64-bit product of the two operands captured at the accepted start. This includes operands of all ones, where the adder's carry-out must not be lost.
- R6: While `busyO` is 0 and no start is accepted, `productO` holds its value from one cycle to the next.
- R7: A `startI` pulse arriving while `busyO` is 1 is ignored. The running operation keeps its operands, its 32-cycle length and its result.
- R8: A zero in either operand gives a product of 0.
- R9: Changes on the operand inputs after the accepting edge have no effect on the running operation or its result.
- R10: In every busy cycle the lower product bits move down one place: `productO[30:0]` in the next cycle equals `productO[31:1]` in this one.
- R11: A start accepted in the same cycle that `doneO` is 1 begins a new operation directly, with the same timing as a start from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| startI | input | 1 | Request to begin a multiplication; acted on only while idle |
| multiplicandI | input | 32 | Unsigned multiplicand, sampled at the accepting edge |
| multiplierI | input | 32 | Unsigned multiplier, sampled at the accepting edge |
| busyO | output | 1 | High while the iterations run |
| doneO | output | 1 | One-cycle pulse when the product is final |
| productO | output | 64 | Product register contents; the final product after `doneO` |

## Verification
The assertions assume that `startI` and both operand inputs hold known values at every rising edge. They treat `startI` as a level sampled each edge, not as an edge-detected event. The operands matter only at the edge where a start is accepted. The bench drives all inputs on the falling edge and samples the outputs just after it, so every value is settled well before the rising edge that uses it. The bench deliberately moves the operand inputs and raises `startI` in the middle of a run. This exercises the assumption that only the accepting edge matters.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic load;  // capture operands, clear upper half
    logic step;  // one conditional add and right shift
  } mulCtrl_t;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } mulPhase_t;

endpackage

// File: rtl/shmul_ctrl.sv
module shmul_ctrl
  import shmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startI,
  output mulCtrl_t ctrlO,
  output logic     busyO,
  output logic     doneO
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mulPhase_t   phaseQ;
  logic [CW-1:0] iterQ;
  logic        doneQ;
  logic        lastStep;

  always_comb begin
    ctrlO.load = startI && (phaseQ == PH_IDLE);
    ctrlO.step = (phaseQ == PH_RUN);
    lastStep   = (phaseQ == PH_RUN) && (iterQ == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      iterQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= lastStep;
      if (ctrlO.load) begin
        phaseQ <= PH_RUN;
        iterQ  <= '0;
      end else if (ctrlO.step) begin
        iterQ <= iterQ + 1'b1;
        if (lastStep) begin
          phaseQ <= PH_IDLE;
        end
      end
    end
  end

  assign busyO = (phaseQ == PH_RUN);
  assign doneO = doneQ;

endmodule

// File: rtl/shmul_datapath.sv
module shmul_datapath
  import shmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mulCtrl_t     ctrlI,
  input  logic [W-1:0] mcandI,
  input  logic [W-1:0] mplierI,
  output logic [2*W-1:0] prodO
);

  localparam int PW = 2 * W;

  logic [W-1:0]  mcandQ;
  logic [PW-1:0] prodQ;
  logic [W-1:0]  addend;
  logic [W:0]    upperSum;
  logic [PW-1:0] prodNext;

  // Only the upper half passes through the adder; carry-out is kept.
  always_comb begin
    addend   = prodQ[0] ? mcandQ : '0;
    upperSum = {1'b0, prodQ[PW-1:W]} + {1'b0, addend};
    prodNext = {upperSum, prodQ[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandQ <= '0;
      prodQ  <= '0;
    end else if (ctrlI.load) begin
      mcandQ <= mcandI;
      prodQ  <= {{W{1'b0}}, mplierI};
    end else if (ctrlI.step) begin
      prodQ <= prodNext;
    end
  end

  assign prodO = prodQ;

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import shmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startI,
  input  logic [W-1:0]   multiplicandI,
  input  logic [W-1:0]   multiplierI,
  output logic           busyO,
  output logic           doneO,
  output logic [2*W-1:0] productO
);

  mulCtrl_t ctrl;

  shmul_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startI (startI),
    .ctrlO  (ctrl),
    .busyO  (busyO),
    .doneO  (doneO)
  );

  shmul_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlI   (ctrl),
    .mcandI  (multiplicandI),
    .mplierI (multiplierI),
    .prodO   (productO)
  );

endmodule

// File: rtl/shmul_chk.sv
module shmul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           startI,
  input logic [W-1:0]   multiplierI,
  input logic           busyO,
  input logic           doneO,
  input logic [2*W-1:0] productO
);

  localparam int RW = $clog2(W) + 1;

  logic [RW-1:0] runLen;
  logic          busyPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen   <= '0;
      busyPrev <= 1'b0;
    end else begin
      busyPrev <= busyO;
      runLen   <= busyO ? runLen + 1'b1 : '0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!busyO && !doneO && productO == '0));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startI && !busyO) |=> (busyO && productO[2*W-1:W] == '0
                            && productO[W-1:0] == $past(multiplierI)));

  // R3
  run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && busyPrev) |-> (runLen == RW'(W)));

  // R3
  run_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyO |-> (runLen < RW'(W)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  // R4
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (!busyO && busyPrev));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && !startI) |=> $stable(productO));

  // R10
  shift_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyO |=> (productO[W-2:0] == $past(productO[W-1:1])));

endmodule

bind shift_add_mult shmul_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startI      (startI),
  .multiplierI (multiplierI),
  .busyO       (busyO),
  .doneO       (doneO),
  .productO    (productO)
);

// File: tb/shift_add_mult_tb.sv
module shift_add_mult_tb;

  localparam int W  = 32;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startI = 1'b0;
  logic [W-1:0]  multiplicandI = '0;
  logic [W-1:0]  multiplierI = '0;
  logic          busyO;
  logic          doneO;
  logic [PW-1:0] productO;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shift_add_mult #(.W(W)) u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .startI        (startI),
    .multiplicandI (multiplicandI),
    .multiplierI   (multiplierI),
    .busyO         (busyO),
    .doneO         (doneO),
    .productO      (productO)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Full run: start, optional disturbance, count busy, check result.
  // mode 0: plain; 1: start pulse mid-run (R7); 2: operands change mid-run (R9)
  task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int mode, input string tag);
    logic [PW-1:0] exp;
    int busyCnt;
    exp = PW'(a) * PW'(b);
    multiplicandI = a;
    multiplierI   = b;
    startI        = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    // R2: loaded register, busy raised
    check(busyO == 1'b1, {tag, " R2 busy"}, PW'(busyO), 1);
    check(productO == {{W{1'b0}}, b}, {tag, " R2 load"}, productO, {{W{1'b0}}, b});
    busyCnt = 1;
    @(negedge clk);
    // R10: lower bits moved down one place after first step
    check(productO[W-2:0] == b[W-1:1], {tag, " R10 shift"},
          PW'(productO[W-2:0]), PW'(b[W-1:1]));
    if (mode == 1) begin
      multiplicandI = ~a;
      multiplierI   = b ^ 32'h5A5A_5A5A;
      startI        = 1'b1;
      @(negedge clk);
      startI = 1'b0;
      busyCnt++;
    end else if (mode == 2) begin
      multiplicandI = a + 32'd12345;
      multiplierI   = ~b;
    end
    while (busyO && busyCnt < 200) begin
      busyCnt++;
      @(negedge clk);
    end
    // R3: run length
    check(busyCnt == W, {tag, " R3 length"}, PW'(busyCnt), PW'(W));
    // R4: done at end of run
    check(doneO == 1'b1, {tag, " R4 done"}, PW'(doneO), 1);
    // R5 / R7 / R8 / R9: product
    check(productO == exp, {tag, " R5 product"}, productO, exp);
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busyO && !doneO && productO == '0, "R1 in reset", productO, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busyO && !doneO && productO == '0, "R1 after reset", productO, '0);
  endtask

  task automatic test_hold();
    logic [PW-1:0] snap;
    run_mult(32'd1234567, 32'd7654321, 0, "hold");
    snap = productO;
    multiplicandI = 32'hFFFF_0000;
    multiplierI   = 32'h0000_FFFF;
    @(negedge clk);
    // R4: single-cycle pulse
    check(doneO == 1'b0, "R4 pulse width", PW'(doneO), 0);
    repeat (5) @(negedge clk);
    // R6: product held while idle
    check(productO == snap, "R6 hold", productO, snap);
  endtask

  task automatic test_back_to_back();
    // R11: start while done is high is accepted
    run_mult(32'd3, 32'd5, 0, "b2b first");
    run_mult(32'hDEAD_BEEF, 32'h0000_0101, 0, "R11 b2b second");
  endtask

  initial begin
    test_reset();
    run_mult(32'd2, 32'd11, 0, "small");
    run_mult(32'd0, 32'hFFFF_FFFF, 0, "R8 zero mcand");
    run_mult(32'hFFFF_FFFF, 32'd0, 0, "R8 zero mplier");
    run_mult(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R5 max carry");
    run_mult(32'hFFFF_FFFF, 32'd1, 0, "max by one");
    run_mult(32'h8000_0000, 32'h8000_0000, 0, "top bits");
    run_mult(32'h1234_5678, 32'h9ABC_DEF0, 1, "R7 ignored start");
    run_mult(32'h0F0F_0F0F, 32'hF0F0_F0F0, 2, "R9 operand change");
    test_hold();
    test_back_to_back();
    for (int i = 0; i < 8; i++) begin
      run_mult($urandom, $urandom, 0, "R5 random");
    end
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule